// File: doc/BRIEF.md
# Execute and Writeback Back End

This block is the back half of a small in-order processor. A decode front end hands it fully decoded instruction templates. They land in a bounded template buffer. One template per cycle leaves the buffer into an execute step, which does one of four things:

- sums two operands;
- resolves a branch that tests a value against zero;
- issues a read to data memory;
- issues a write to data memory.

Every instruction that still owes the machine something leaves a record in a short execute-to-writeback queue. The writeback step retires these records in order. It drives the register-file write port that belongs to the front end. For memory records it first consumes the matching response from the split request/response data memory.

A taken branch redirects fetch and flushes the template buffer, because everything behind it is on the wrong path. The writeback queue is left intact, because everything in it is older than the branch and must commit. The block also produces the decode stall signal. It compares the source registers of the instruction being decoded against every destination that has not yet been written back.

Top module: `exwb_backend`

## Requirements
- R1: A template is packed, from the most significant bit down, as a 2-bit kind (00 add, 01 branch-if-zero, 10 load, 11 store), a REG_W destination, a DATA_W field A and a DATA_W field B in the least significant bits. An add writes A+B, modulo 2^DATA_W, to its destination through the register write port.
- R2: A branch-if-zero whose field A is zero raises redirect_valid for exactly one cycle. redirect_pc carries the low ADDR_W bits of field B. The branch writes no register.
- R3: A taken branch discards every template queued behind it. A template offered on tpl_data in the same cycle as the redirect is not accepted.
- R4: A branch-if-zero with a non-zero field A raises no redirect, and the templates that follow it execute normally.
- R5: A redirect does not remove any writeback-queue record. Loads executed before a taken branch still write their register.
- R6: A load issues a read request at the address in the low ADDR_W bits of field A. Writeback holds the load's record until dmem_rsp_valid, then writes dmem_rsp_data to the destination.
- R7: A store issues a write request with the address from field A and the data from field B. Writeback waits for the store's acknowledge response before any younger record retires, and writes no register for it.
- R8: Register writes appear in the order the templates were executed, with no extra or missing writes.
- R9: stall is high when dec_src_a or dec_src_b equals the destination of a buffered add or load template, or of a writeback-queue record for an add or a load. Otherwise stall is low.
- R10: Adds, loads and stores do not execute while the writeback queue is full (no memory request is issued), whereas a branch does not wait for queue space. tpl_ready is low while the template buffer is full.
- R11: After reset both queues are empty, tpl_ready is high, and rf_we, redirect_valid, dmem_req_valid and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpl_valid | input | 1 | A decoded template is offered |
| tpl_data | input | 2+REG_W+2*DATA_W | Packed template |
| tpl_ready | output | 1 | Template buffer has room |
| dec_src_a | input | REG_W | First source register of the decoding instruction |
| dec_src_b | input | REG_W | Second source register of the decoding instruction |
| stall | output | 1 | Decode must hold: read-after-write hazard |
| redirect_valid | output | 1 | Taken branch: fetch must restart |
| redirect_pc | output | ADDR_W | Fetch restart address |
| dmem_req_valid | output | 1 | Data memory request |
| dmem_req_write | output | 1 | Request is a write |
| dmem_req_addr | output | ADDR_W | Request address |
| dmem_req_wdata | output | DATA_W | Write data |
| dmem_rsp_valid | input | 1 | Memory response present |
| dmem_rsp_data | input | DATA_W | Read data, or don't-care for a write acknowledge |
| dmem_rsp_ready | output | 1 | Writeback takes the response this cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The bench fills the writeback queue with slow loads so that a taken branch sits behind a blocked add, with a further template buffered after it. A design that flushed the wrong structure would then lose a load result, or retire the squashed add as an extra register write.

A second branch is followed in the very next cycle by a template. A design that accepted that same-cycle template would execute a wrong-path instruction.

A store is placed between a load and a load from the same address. A writeback that skipped the acknowledge would retire the younger record early, and the scoreboard would see the writes out of order or the wrong data.

Stall is probed while a hazard destination exists only in the buffer, only in the queue, and nowhere. A comparison that ignored one structure shows up as a missing stall.

// File: rtl/exwb_pkg.sv
package exwb_pkg;

   // template kind tag, top two bits of a template
   typedef enum logic [1:0] {
      K_ADD   = 2'b00,
      K_BZ    = 2'b01,
      K_LOAD  = 2'b10,
      K_STORE = 2'b11
   } tkind_e;

   // writeback record kind, top two bits of a record
   typedef enum logic [1:0] {
      W_ALU = 2'b00,
      W_LD  = 2'b01,
      W_ST  = 2'b10
   } wkind_e;

endpackage

// File: rtl/exwb_fifo.sv
module exwb_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic [W-1:0]         din,
   input  logic                 pop,
   input  logic                 flush,
   output logic [W-1:0]         head,
   output logic                 full,
   output logic                 empty,
   output logic [CNT_W-1:0]     count,
   output logic [DEPTH*W-1:0]   slots,
   output logic [DEPTH-1:0]     slot_vld
);

   initial begin
      assert (DEPTH >= 1 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("exwb_fifo: DEPTH must be a power of two");
      assert (W >= 1) else $error("exwb_fifo: W must be positive");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] data_q;
         logic         vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     vld_q <= 1'b0;
            else if (flush) vld_q <= 1'b0;
            else if (push)  vld_q <= 1'b1;
            else if (pop)   vld_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push && !flush) data_q <= din;
         end

         assign head     = data_q;
         assign slots    = data_q;
         assign slot_vld = vld_q;
         assign count    = vld_q;
         assign full     = vld_q;
         assign empty    = !vld_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [W-1:0]       mem_q [DEPTH];
         logic [PTR_W-1:0]   rd_q, wr_q;
         logic [CNT_W-1:0]   cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else if (flush) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wr_q <= wr_q + 1'b1;
               if (pop)  rd_q <= rd_q + 1'b1;
               cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
            end
         end

         always_ff @(posedge clk) begin
            if (push && !flush) mem_q[wr_q] <= din;
         end

         for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [PTR_W-1:0] offs;
            assign offs                = PTR_W'(i) - rd_q;
            assign slots[i*W +: W]     = mem_q[i];
            assign slot_vld[i]         = {1'b0, offs} < cnt_q;
         end

         assign head  = mem_q[rd_q];
         assign count = cnt_q;
         assign full  = (cnt_q == CNT_W'(DEPTH));
         assign empty = (cnt_q == '0);
      end
   endgenerate

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> !full);

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty);

endmodule

// File: rtl/exwb_hazard.sv
module exwb_hazard #(
   parameter int REG_W = 4,
   parameter int N_TPL = 4,
   parameter int N_WBQ = 2
) (
   input  logic [REG_W-1:0]        src_a,
   input  logic [REG_W-1:0]        src_b,
   input  logic [N_TPL*REG_W-1:0]  tpl_dst,
   input  logic [N_TPL-1:0]        tpl_wr,
   input  logic [N_WBQ*REG_W-1:0]  wbq_dst,
   input  logic [N_WBQ-1:0]        wbq_wr,
   output logic                    stall
);

   logic [N_TPL-1:0] tpl_hit;
   logic [N_WBQ-1:0] wbq_hit;

   for (genvar i = 0; i < N_TPL; i++) begin : g_tcmp
      logic [REG_W-1:0] d;
      assign d          = tpl_dst[i*REG_W +: REG_W];
      assign tpl_hit[i] = tpl_wr[i] && (d == src_a || d == src_b);
   end

   for (genvar j = 0; j < N_WBQ; j++) begin : g_wcmp
      logic [REG_W-1:0] d;
      assign d          = wbq_dst[j*REG_W +: REG_W];
      assign wbq_hit[j] = wbq_wr[j] && (d == src_a || d == src_b);
   end

   assign stall = (|tpl_hit) || (|wbq_hit);

endmodule

// File: rtl/exwb_backend.sv
module exwb_backend
   import exwb_pkg::*;
#(
   parameter  int DATA_W    = 16,
   parameter  int ADDR_W    = 8,
   parameter  int REG_W     = 4,
   parameter  int TPL_DEPTH = 4,
   parameter  int WBQ_DEPTH = 2,
   localparam int TPL_W     = 2 + REG_W + 2 * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tpl_valid,
   input  logic [TPL_W-1:0]   tpl_data,
   output logic               tpl_ready,
   input  logic [REG_W-1:0]   dec_src_a,
   input  logic [REG_W-1:0]   dec_src_b,
   output logic               stall,
   output logic               redirect_valid,
   output logic [ADDR_W-1:0]  redirect_pc,
   output logic               dmem_req_valid,
   output logic               dmem_req_write,
   output logic [ADDR_W-1:0]  dmem_req_addr,
   output logic [DATA_W-1:0]  dmem_req_wdata,
   input  logic               dmem_rsp_valid,
   input  logic [DATA_W-1:0]  dmem_rsp_data,
   output logic               dmem_rsp_ready,
   output logic               rf_we,
   output logic [REG_W-1:0]   rf_waddr,
   output logic [DATA_W-1:0]  rf_wdata
);

   localparam int WB_W   = 2 + REG_W + DATA_W;
   localparam int TCNT_W = $clog2(TPL_DEPTH) + 1;
   localparam int QCNT_W = $clog2(WBQ_DEPTH) + 1;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= DATA_W)
         else $error("exwb_backend: ADDR_W must lie in 1..DATA_W");
      assert (REG_W >= 1) else $error("exwb_backend: REG_W must be positive");
   end

   // ---------------- template buffer ----------------
   logic                      tb_push, tb_pop, tb_flush, tb_full, tb_empty;
   logic [TPL_W-1:0]          tb_head;
   logic [TCNT_W-1:0]         tb_cnt;
   logic [TPL_DEPTH*TPL_W-1:0] tb_slots;
   logic [TPL_DEPTH-1:0]      tb_vld;

   exwb_fifo #(.W(TPL_W), .DEPTH(TPL_DEPTH)) u_tbuf (
      .clk(clk), .rst_n(rst_n), .push(tb_push), .din(tpl_data), .pop(tb_pop),
      .flush(tb_flush), .head(tb_head), .full(tb_full), .empty(tb_empty),
      .count(tb_cnt), .slots(tb_slots), .slot_vld(tb_vld));

   // ---------------- writeback queue ----------------
   logic                       wq_push, wq_pop, wq_full, wq_empty;
   logic [WB_W-1:0]            wq_din, wq_head;
   logic [QCNT_W-1:0]          wq_cnt;
   logic [WBQ_DEPTH*WB_W-1:0]  wq_slots;
   logic [WBQ_DEPTH-1:0]       wq_vld;

   exwb_fifo #(.W(WB_W), .DEPTH(WBQ_DEPTH)) u_wbq (
      .clk(clk), .rst_n(rst_n), .push(wq_push), .din(wq_din), .pop(wq_pop),
      .flush(1'b0), .head(wq_head), .full(wq_full), .empty(wq_empty),
      .count(wq_cnt), .slots(wq_slots), .slot_vld(wq_vld));

   // ---------------- execute ----------------
   tkind_e            head_k;
   logic [REG_W-1:0]  h_dst;
   logic [DATA_W-1:0] h_fa, h_fb;
   logic              needs_q, fire, taken;

   assign head_k  = tkind_e'(tb_head[TPL_W-1 -: 2]);
   assign h_dst   = tb_head[2*DATA_W +: REG_W];
   assign h_fa    = tb_head[DATA_W +: DATA_W];
   assign h_fb    = tb_head[0 +: DATA_W];

   assign needs_q = (head_k != K_BZ);
   assign fire    = !tb_empty && (!needs_q || !wq_full);
   assign taken   = fire && (head_k == K_BZ) && (h_fa == '0);

   assign tpl_ready = !tb_full;
   assign tb_push   = tpl_valid && !tb_full;
   assign tb_pop    = fire;
   assign tb_flush  = taken;

   assign redirect_valid = taken;
   assign redirect_pc    = h_fb[ADDR_W-1:0];

   assign dmem_req_valid = fire && (head_k == K_LOAD || head_k == K_STORE);
   assign dmem_req_write = (head_k == K_STORE);
   assign dmem_req_addr  = h_fa[ADDR_W-1:0];
   assign dmem_req_wdata = h_fb;

   assign wq_push = fire && needs_q;

   always_comb begin
      wq_din = '0;
      unique case (head_k)
         K_ADD:   wq_din = {W_ALU, h_dst, h_fa + h_fb};
         K_LOAD:  wq_din = {W_LD, h_dst, {DATA_W{1'b0}}};
         K_STORE: wq_din = {W_ST, {REG_W{1'b0}}, {DATA_W{1'b0}}};
         default: wq_din = '0;
      endcase
   end

   // ---------------- writeback ----------------
   wkind_e            q_k;
   logic [REG_W-1:0]  q_dst;
   logic [DATA_W-1:0] q_val;
   logic              wb_mem;

   assign q_k    = wkind_e'(wq_head[WB_W-1 -: 2]);
   assign q_dst  = wq_head[DATA_W +: REG_W];
   assign q_val  = wq_head[0 +: DATA_W];

   assign wb_mem         = !wq_empty && (q_k == W_LD || q_k == W_ST);
   assign dmem_rsp_ready = wb_mem;
   assign wq_pop         = !wq_empty && (q_k == W_ALU || dmem_rsp_valid);

   assign rf_we    = !wq_empty && (q_k == W_ALU || (q_k == W_LD && dmem_rsp_valid));
   assign rf_waddr = q_dst;
   assign rf_wdata = (q_k == W_LD) ? dmem_rsp_data : q_val;

   // ---------------- hazard detection ----------------
   logic [TPL_DEPTH*REG_W-1:0] tpl_dst;
   logic [TPL_DEPTH-1:0]       tpl_wr;
   logic [WBQ_DEPTH*REG_W-1:0] wbq_dst;
   logic [WBQ_DEPTH-1:0]       wbq_wr;

   for (genvar i = 0; i < TPL_DEPTH; i++) begin : g_tslot
      logic [TPL_W-1:0] e;
      assign e                        = tb_slots[i*TPL_W +: TPL_W];
      assign tpl_dst[i*REG_W +: REG_W] = e[2*DATA_W +: REG_W];
      assign tpl_wr[i] = tb_vld[i] && (e[TPL_W-1 -: 2] == K_ADD || e[TPL_W-1 -: 2] == K_LOAD);
   end

   for (genvar j = 0; j < WBQ_DEPTH; j++) begin : g_qslot
      logic [WB_W-1:0] e;
      assign e                        = wq_slots[j*WB_W +: WB_W];
      assign wbq_dst[j*REG_W +: REG_W] = e[DATA_W +: REG_W];
      assign wbq_wr[j] = wq_vld[j] && (e[WB_W-1 -: 2] == W_ALU || e[WB_W-1 -: 2] == W_LD);
   end

   exwb_hazard #(.REG_W(REG_W), .N_TPL(TPL_DEPTH), .N_WBQ(WBQ_DEPTH)) u_haz (
      .src_a(dec_src_a), .src_b(dec_src_b), .tpl_dst(tpl_dst), .tpl_wr(tpl_wr),
      .wbq_dst(wbq_dst), .wbq_wr(wbq_wr), .stall(stall));

   // ---------------- assertions ----------------
   // R3
   redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> tb_empty);

   // R5
   wbq_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && !wq_pop) |=> (wq_cnt >= $past(wq_cnt)));

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_mem && !dmem_rsp_valid) |=> $stable(wq_head));

   // R7
   store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_mem && q_k == W_ST) |-> !rf_we);

   // R8
   wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !wq_empty);

   // R6
   req_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_req_valid |=> !wq_empty);

endmodule

// File: tb/exwb_backend_tb_top.sv
`timescale 1ns/1ps
module exwb_backend_tb_top;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 8;
   localparam int REG_W  = 4;
   localparam int TPL_W  = 2 + REG_W + 2 * DATA_W;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               tpl_valid;
   logic [TPL_W-1:0]   tpl_data;
   logic               tpl_ready;
   logic [REG_W-1:0]   dec_src_a, dec_src_b;
   logic               stall;
   logic               redirect_valid;
   logic [ADDR_W-1:0]  redirect_pc;
   logic               dmem_req_valid, dmem_req_write;
   logic [ADDR_W-1:0]  dmem_req_addr;
   logic [DATA_W-1:0]  dmem_req_wdata;
   logic               dmem_rsp_valid;
   logic [DATA_W-1:0]  dmem_rsp_data;
   logic               dmem_rsp_ready;
   logic               rf_we;
   logic [REG_W-1:0]   rf_waddr;
   logic [DATA_W-1:0]  rf_wdata;

   exwb_backend dut_i (
      .clk(clk), .rst_n(rst_n), .tpl_valid(tpl_valid), .tpl_data(tpl_data),
      .tpl_ready(tpl_ready), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .stall(stall), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .dmem_req_valid(dmem_req_valid), .dmem_req_write(dmem_req_write),
      .dmem_req_addr(dmem_req_addr), .dmem_req_wdata(dmem_req_wdata),
      .dmem_rsp_valid(dmem_rsp_valid), .dmem_rsp_data(dmem_rsp_data),
      .dmem_rsp_ready(dmem_rsp_ready), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata));

   always #2 clk = ~clk;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // scoreboard queues
   logic [REG_W+DATA_W-1:0] exp_wr [$];
   logic [ADDR_W-1:0]       exp_rd [$];

   // memory model
   logic [DATA_W-1:0] bmem [256];
   logic [DATA_W-1:0] pq_data [$];
   int                pq_due  [$];
   int                cyc      = 0;
   int                mem_lat  = 2;
   bit                consumed = 1'b0;

   function automatic logic [DATA_W-1:0] bm_init(input int i);
      return DATA_W'(i * 257) ^ 16'h5a5a;
   endfunction

   function automatic logic [TPL_W-1:0] mk_tpl(input logic [1:0] k, input logic [REG_W-1:0] d,
                                               input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      return {k, d, a, b};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   // driver: offers one template, pushes expected results if accepted
   task automatic send(input logic [TPL_W-1:0] t, input bit expw, input logic [REG_W-1:0] d,
                       input logic [DATA_W-1:0] v, output bit acc);
      @(negedge clk);
      tpl_valid = 1'b1;
      tpl_data  = t;
      while (!tpl_ready) @(negedge clk);
      acc = !redirect_valid;
      if (acc && expw) exp_wr.push_back({d, v});
      if (acc && t[TPL_W-1 -: 2] == 2'b01 && t[DATA_W +: DATA_W] == '0)
         exp_rd.push_back(t[ADDR_W-1:0]);
      @(posedge clk);
      #1 tpl_valid = 1'b0;
   endtask

   task automatic stall_chk(input logic [REG_W-1:0] s, input bit expv, input string rq);
      @(negedge clk);
      dec_src_a = s;
      dec_src_b = s;
      #1 chk(stall == expv, rq, $sformatf("stall for r%0d", s), stall, expv);
   endtask

   // monitor plus memory request/ack sampling, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rf_we) begin
            vectors++;
            if (exp_wr.size() == 0) begin
               errors++;
               $display("FAIL R8 unexpected write: actual r%0d=%0h expected none", rf_waddr, rf_wdata);
            end else begin
               logic [REG_W+DATA_W-1:0] e;
               e = exp_wr.pop_front();
               if (e != {rf_waddr, rf_wdata}) begin
                  errors++;
                  $display("FAIL R1/R6/R8 write: actual r%0d=%0h expected r%0d=%0h",
                           rf_waddr, rf_wdata, e[DATA_W +: REG_W], e[DATA_W-1:0]);
               end
            end
         end
         if (redirect_valid) begin
            vectors++;
            if (exp_rd.size() == 0) begin
               errors++;
               $display("FAIL R2 unexpected redirect: actual %0h expected none", redirect_pc);
            end else begin
               logic [ADDR_W-1:0] r;
               r = exp_rd.pop_front();
               if (r != redirect_pc) begin
                  errors++;
                  $display("FAIL R2 redirect target: actual %0h expected %0h", redirect_pc, r);
               end
            end
         end
      end
      if (rst_n && dmem_req_valid) begin
         if (dmem_req_write) begin
            bmem[dmem_req_addr] = dmem_req_wdata;
            pq_data.push_back('0);
         end else begin
            pq_data.push_back(bmem[dmem_req_addr]);
         end
         pq_due.push_back(cyc + mem_lat);
      end
      consumed = dmem_rsp_valid && dmem_rsp_ready;
   end

   always @(posedge clk) begin
      #1;
      cyc++;
      if (consumed) begin
         void'(pq_data.pop_front());
         void'(pq_due.pop_front());
         consumed = 1'b0;
      end
      if (pq_data.size() != 0 && cyc >= pq_due[0]) begin
         dmem_rsp_valid = 1'b1;
         dmem_rsp_data  = pq_data[0];
      end else begin
         dmem_rsp_valid = 1'b0;
         dmem_rsp_data  = '0;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic drain();
      repeat (80) @(negedge clk);
   endtask

   initial begin
      bit acc;
      for (int i = 0; i < 256; i++) bmem[i] = bm_init(i);
      rst_n = 1'b0; tpl_valid = 1'b0; tpl_data = '0;
      dec_src_a = '0; dec_src_b = '0;
      dmem_rsp_valid = 1'b0; dmem_rsp_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk(tpl_ready == 1'b1, "R11", "tpl_ready", tpl_ready, 1);
      chk(rf_we == 1'b0, "R11", "rf_we", rf_we, 0);
      chk(redirect_valid == 1'b0, "R11", "redirect_valid", redirect_valid, 0);
      chk(dmem_req_valid == 1'b0, "R11", "dmem_req_valid", dmem_req_valid, 0);
      chk(stall == 1'b0, "R11", "stall", stall, 0);

      // R1 adds, including wrap-around
      mem_lat = 2;
      send(mk_tpl(2'b00, 4'd1, 16'd5, 16'd7), 1, 4'd1, 16'd12, acc);
      send(mk_tpl(2'b00, 4'd2, 16'hffff, 16'd2), 1, 4'd2, 16'd1, acc);
      send(mk_tpl(2'b00, 4'd3, 16'h1234, 16'h4321), 1, 4'd3, 16'h5555, acc);
      drain();

      // R6 / R7 load, store, load from stored address, then add
      send(mk_tpl(2'b10, 4'd4, 16'd10, 16'd0), 1, 4'd4, bm_init(10), acc);
      send(mk_tpl(2'b11, 4'd0, 16'd20, 16'habcd), 0, 4'd0, 16'd0, acc);
      send(mk_tpl(2'b10, 4'd5, 16'd20, 16'd0), 1, 4'd5, 16'habcd, acc);
      send(mk_tpl(2'b00, 4'd6, 16'd1, 16'd2), 1, 4'd6, 16'd3, acc);
      drain();

      // R4 not-taken branch
      send(mk_tpl(2'b01, 4'd0, 16'd3, 16'h0040), 0, 4'd0, 16'd0, acc);
      send(mk_tpl(2'b00, 4'd7, 16'd8, 16'd9), 1, 4'd7, 16'd17, acc);
      drain();

      // R2 / R3 taken branch; template in the redirect cycle is refused
      send(mk_tpl(2'b01, 4'd0, 16'd0, 16'h0055), 0, 4'd0, 16'd0, acc);
      send(mk_tpl(2'b00, 4'd8, 16'd1, 16'd1), 1, 4'd8, 16'd2, acc);
      chk(acc == 1'b0, "R3", "same-cycle template accepted", acc, 0);
      send(mk_tpl(2'b00, 4'd9, 16'd4, 16'd4), 1, 4'd9, 16'd8, acc);
      drain();

      // R10 / R9 / R3 slow loads fill the queue; branch squashes buffered adds
      mem_lat = 25;
      send(mk_tpl(2'b10, 4'd10, 16'd30, 16'd0), 1, 4'd10, bm_init(30), acc);
      send(mk_tpl(2'b10, 4'd11, 16'd31, 16'd0), 1, 4'd11, bm_init(31), acc);
      send(mk_tpl(2'b00, 4'd12, 16'd1, 16'd1), 1, 4'd12, 16'd2, acc);
      send(mk_tpl(2'b01, 4'd0, 16'd0, 16'h0077), 0, 4'd0, 16'd0, acc);
      send(mk_tpl(2'b00, 4'd13, 16'd5, 16'd5), 0, 4'd0, 16'd0, acc);
      send(mk_tpl(2'b00, 4'd14, 16'd6, 16'd6), 0, 4'd0, 16'd0, acc);
      @(negedge clk); #1;
      chk(tpl_ready == 1'b0, "R10", "tpl_ready when buffer full", tpl_ready, 0);
      chk(dmem_req_valid == 1'b0, "R10", "request while queue full", dmem_req_valid, 0);
      stall_chk(4'd12, 1'b1, "R9");
      stall_chk(4'd11, 1'b1, "R9");
      stall_chk(4'd14, 1'b1, "R9");
      stall_chk(4'd15, 1'b0, "R9");
      drain();
      stall_chk(4'd10, 1'b0, "R9");

      // R5 taken branch while a load record waits in the queue
      mem_lat = 10;
      send(mk_tpl(2'b10, 4'd3, 16'd40, 16'd0), 1, 4'd3, bm_init(40), acc);
      send(mk_tpl(2'b01, 4'd0, 16'd0, 16'h0011), 0, 4'd0, 16'd0, acc);
      drain();

      chk(exp_wr.size() == 0, "R8", "missing register writes", exp_wr.size(), 0);
      chk(exp_rd.size() == 0, "R2", "missing redirects", exp_rd.size(), 0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule